// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Unit

This block is a clocked signed arithmetic unit. On every enabled clock edge it takes two 27-bit signed addends and an 18-bit signed factor. It forms the sum of the two addends, multiplies that sum by the factor, and adds the product into a 48-bit signed running total. The running total is the block's only output.

The data path has four register stages: an input stage, a pre-adder stage, a multiplier stage and the accumulator. A set of operands therefore shows up in the output a fixed number of edges after it is captured.

A synchronous active-high clear empties every stage and the total. A clock enable freezes the whole unit while it is low. The block suits filter taps, correlators and dot products where one operand is formed as a sum, for example the two samples that share a coefficient in a symmetric filter.

Top module: `preadd_mac`

## Requirements
- R1: On every enabled edge without clear, the total grows by (a_in + d_in) * b_in of the operand set that entered three enabled edges earlier, so that acc_out follows P(i) = (A + D) * B + P(i-1).
- R2: An operand set present at enabled edge t is first included in acc_out just after enabled edge t+3. That is four register stages, counting the capture edge.
- R3: The sum a_in + d_in is held at 28 bits and never overflows, including when both addends are at the same signed extreme.
- R4: When clr is high at an edge, every stage and acc_out read zero after that edge.
- R5: For the three edges that follow a clearing edge, acc_out stays zero whatever the operands are.
- R6: While ce is low and clr is low, acc_out and every internal stage keep their values, whatever the operands do.
- R7: clr takes effect even when ce is low.
- R8: The total wraps modulo 2^48 on overflow and never saturates.
- R9: Products and sums are signed two's complement, and the product is sign-extended to 48 bits before accumulation, so negative products lower the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| ce | input | 1 | Clock enable; when low, all stages hold |
| clr | input | 1 | Synchronous clear, active high, overrides ce |
| a_in | input | 27 | First signed addend |
| d_in | input | 27 | Second signed addend |
| b_in | input | 18 | Signed factor |
| acc_out | output | 48 | Signed running total |

## Verification
On every cycle, the assertions check the following:
- the zero state after a clear and during the three edges that follow it;
- the freeze of both the multiplier stage and the total while the enable is low;
- the multiplier stage holding the exact signed product of the operands captured three enabled edges before.

Several behaviours can only be shown by the bench's scenarios:
- the sign extension of the product into the total;
- the modulo-2^48 wrap after many large products;
- the precedence of the clear over a low enable;
- the cycle at which a lone operand set first shows up in the output.

// File: rtl/preadd_mac.sv
module preadd_mac #(
  parameter int AW = 27,
  parameter int BW = 18,
  parameter int PW = 48
) (
  input  logic                 clk,
  input  logic                 ce,
  input  logic                 clr,
  input  logic signed [AW-1:0] a_in,
  input  logic signed [AW-1:0] d_in,
  input  logic signed [BW-1:0] b_in,
  output logic signed [PW-1:0] acc_out
);

  localparam int SW = AW + 1;
  localparam int MW = SW + BW;

  logic signed [AW-1:0] a_q, d_q;
  logic signed [BW-1:0] b_q, b2_q;
  logic signed [SW-1:0] sum_q;
  logic signed [MW-1:0] prod_q;
  logic signed [PW-1:0] acc_q;

  wire signed [SW-1:0] sum_w  = $signed({a_q[AW-1], a_q}) + $signed({d_q[AW-1], d_q});
  wire signed [MW-1:0] prod_w = MW'(sum_q) * MW'(b2_q);
  wire signed [PW-1:0] prod_x = PW'(prod_q);

  always_ff @(posedge clk) begin
    if (clr) begin
      a_q    <= '0;
      d_q    <= '0;
      b_q    <= '0;
      b2_q   <= '0;
      sum_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else if (ce) begin
      a_q    <= a_in;
      d_q    <= d_in;
      b_q    <= b_in;
      sum_q  <= sum_w;
      b2_q   <= b_q;
      prod_q <= prod_w;
      acc_q  <= acc_q + prod_x;
    end
  end

  assign acc_out = acc_q;

  function automatic logic signed [MW-1:0] ref_prod(
    input logic signed [AW-1:0] a,
    input logic signed [AW-1:0] d,
    input logic signed [BW-1:0] b
  );
    logic signed [SW-1:0] s;
    s = SW'(a) + SW'(d);
    return MW'(s) * MW'(b);
  endfunction

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (acc_out == '0 && prod_q == '0 && sum_q == '0));

  assert_quiet_two_R5: assert property (@(posedge clk) disable iff (clr)
    $past(clr, 2) |-> acc_out == '0);

  assert_quiet_three_R5: assert property (@(posedge clk) disable iff (clr)
    $past(clr, 3) |-> acc_out == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (clr)
    !ce |=> ($stable(acc_out) && $stable(prod_q)));

  assert_product_path_R3: assert property (@(posedge clk) disable iff (clr)
    ($past(ce, 1) && $past(ce, 2) && $past(ce, 3) &&
     !$past(clr, 1) && !$past(clr, 2) && !$past(clr, 3))
    |-> prod_q == ref_prod($past(a_in, 3), $past(d_in, 3), $past(b_in, 3)));

endmodule

// File: tb/test_preadd_mac.sv
`timescale 1ns/1ps
module test_preadd_mac;

  logic clk = 1'b0;
  logic ce = 1'b0;
  logic clr = 1'b1;
  logic signed [26:0] a_in = '0, d_in = '0;
  logic signed [17:0] b_in = '0;
  logic signed [47:0] acc_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint m_p1 = 0, m_p2 = 0, m_p3 = 0;
  logic [47:0] m_acc = '0;

  always #2.5 clk = ~clk;

  preadd_mac i_preadd_mac (
    .clk(clk), .ce(ce), .clr(clr),
    .a_in(a_in), .d_in(d_in), .b_in(b_in),
    .acc_out(acc_out)
  );

  function automatic longint exp_prod(longint a, longint d, longint b);
    return (a + d) * b;
  endfunction

  task automatic check(input logic [47:0] got, input logic [47:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(got), $signed(exp));
    end
  endtask

  task automatic step(input longint a, input longint d, input longint b,
                      input bit en, input bit cl, input string req);
    longint sa, sd, sb;
    a_in = 27'(a); d_in = 27'(d); b_in = 18'(b); ce = en; clr = cl;
    sa = a_in; sd = d_in; sb = b_in;
    @(posedge clk);
    if (cl) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_acc = '0;
    end else if (en) begin
      m_acc = m_acc + 48'(m_p3);
      m_p3 = m_p2; m_p2 = m_p1;
      m_p1 = exp_prod(sa, sd, sb);
    end
    @(negedge clk);
    check(acc_out, m_acc, req);
  endtask

  function automatic longint rnd(int bits);
    longint v;
    v = longint'($urandom);
    v = v & ((64'sd1 <<< bits) - 1);
    if (v >= (64'sd1 <<< (bits - 1))) v = v - (64'sd1 <<< bits);
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] held;
    void'($urandom(32'd20240917));
    @(negedge clk);
    step(5, 6, 7, 1, 1, "R4");
    step(5, 6, 7, 1, 1, "R4");
    check(acc_out, 48'd0, "R4");

    // R5 / R2: lone operand set then zeros
    step(5, 3, 7, 1, 0, "R2");
    check(acc_out, 48'd0, "R5");
    step(0, 0, 0, 1, 0, "R2");
    check(acc_out, 48'd0, "R5");
    step(0, 0, 0, 1, 0, "R2");
    check(acc_out, 48'd0, "R5");
    step(0, 0, 0, 1, 0, "R2");
    check(acc_out, 48'd56, "R2");

    // R1: random full-range stream
    for (int i = 0; i < 80; i++) step(rnd(27), rnd(27), rnd(18), 1, 0, "R1");
    for (int i = 0; i < 40; i++) step(rnd(18), rnd(8), rnd(8), 1, 0, "R1");

    // R6: enable low with changing operands
    step(0, 0, 0, 1, 0, "R6");
    held = acc_out;
    for (int i = 0; i < 10; i++) begin
      step(rnd(27), rnd(27), rnd(18), 0, 0, "R6");
      check(acc_out, held, "R6");
    end
    for (int i = 0; i < 30; i++) step(rnd(27), rnd(27), rnd(18), (i % 3) != 0, 0, "R6");

    // R7: clear while enable low
    step(9, 9, 9, 0, 1, "R7");
    check(acc_out, 48'd0, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R7");
    check(acc_out, 48'd0, "R7");

    // R3: both addends at the same extreme
    step(-(64'sd1 <<< 26), -(64'sd1 <<< 26), -(64'sd1 <<< 17), 1, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R3");
    check(acc_out, 48'sd1 <<< 44, "R3");
    step(0, 0, 0, 1, 1, "R3");
    step((64'sd1 <<< 26) - 1, (64'sd1 <<< 26) - 1, (64'sd1 <<< 17) - 1, 1, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R3");
    check(acc_out, 48'(exp_prod((64'sd1 <<< 26) - 1, (64'sd1 <<< 26) - 1, (64'sd1 <<< 17) - 1)), "R3");

    // R9: negative product lowers total
    step(0, 0, 0, 1, 1, "R9");
    step(-1000, -5, 3, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R9");
    check(acc_out, -48'sd3015, "R9");
    step(7, -2, -4, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R9");
    check(acc_out, -48'sd3035, "R9");

    // R8: repeated maximal products wrap modulo 2^48
    step(0, 0, 0, 1, 1, "R8");
    for (int i = 0; i < 24; i++)
      step(-(64'sd1 <<< 26), -(64'sd1 <<< 26), -(64'sd1 <<< 17), 1, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R8");
    check(acc_out, 48'((64'sd24 <<< 44) & ((64'sd1 <<< 48) - 1)), "R8");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule